// File: doc/BRIEF.md
# JTAG Configuration Register Readback Sequencer

This block is a boundary-scan master for reading one configuration register of a target device. It derives the test clock from the system clock and drives the mode and data-in lines. It also samples the data-out line, so a host only has to give a register address and a start pulse. It then waits for a done strobe and takes the word from the data output.

An access runs in two passes, each opened by a test-logic reset. The first pass loads the configuration-input instruction. It then shifts a command stream into the target as one data-register scan: a synchronization word, a read header carrying the address and a word count of one, and two no-op flush words. The second pass loads the configuration-output instruction and scans one word back out of the target. A final reset returns the target's TAP to Test-Logic-Reset before done is raised. Word width, the synchronization and no-op words, the header tag, the instruction codes and the clock divider are all parameters.

Top module: `jtagCfgReader`

## Requirements
- R1: While reset is asserted and while idle, `tck` is 0, `tms` is 1, `tdi` is 0, and `busy` and `done` are 0. Reset also clears `rdData`.
- R2: `tck` has a period of DIV system clocks, low for DIV/2 and high for the rest. `tms` and `tdi` change only on system clock edges where `tck` falls, and `tdo` is sampled where `tck` rises.
- R3: Each pass opens with five `tck` cycles at `tms`=1, and the access closes with five more. After the opening five, `tms` runs 0, 1, 1, 0, 0 to reach Shift-IR.
- R4: Instructions are 6 bits, sent LSB first. The first five bits go out with `tms`=0 and the last with `tms`=1. The first pass loads binary 000101 and the second loads binary 000100.
- R5: After each instruction, `tms` runs 1, 1, 0, 0 to reach Shift-DR.
- R6: The first pass shifts 4×W bits in one scan, in this order: sync word (default 16'hAA99), header, no-op (default 16'h2000), no-op. Each word goes MSB first, and only the final bit has `tms`=1. The header is {5-bit tag 5'b00101, 6-bit address, 5-bit count = 1}.
- R7: The second pass scans W bits, the last with `tms`=1. The first `tdo` bit sampled becomes the MSB of `rdData`.
- R8: `busy` rises on the clock after an accepted start and stays high until it falls together with a one-cycle `done` pulse. An access takes 45+5×W `tck` cycles.
- R9: A start pulse while `busy` is high is ignored. The current address is kept, and no extra access follows.
- R10: `rdData` stays unchanged while idle after `done`, whatever the address input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an access |
| regAddr | input | ADDR_W | Register address, sampled with start |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion strobe |
| rdData | output | W | Word read back from the target |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data toward the target |
| tdo | input | 1 | Test data from the target |

## Verification
A behavioural TAP controller with a 6-bit instruction register answers the master. It records every `tms` bit, each instruction it latches and every bit scanned into the input register. Register values of all ones, a lone LSB, a lone MSB and a mixed pattern separate MSB-first from LSB-first assembly and catch stuck or dropped bits. Addresses of all zeros, all ones and alternating bits show whether the address field lands in the right header position. A start issued mid-access must leave the first address in the captured header and add no second walk.

// File: rtl/jtagCfgPkg.sv
package jtagCfgPkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_TLR,
    PH_IDLERUN,
    PH_TOIR,
    PH_INTOIR,
    PH_IRBITS,
    PH_TODR,
    PH_INTODR,
    PH_DRBITS
  } phase_t;

  typedef struct packed {
    logic run;
    logic loadCmd;
    logic shiftCmd;
    logic captureBit;
    logic useIr;
    logic irBit;
    logic useCmd;
  } ctl_t;

endpackage

// File: rtl/jtagCfgCtrl.sv
module jtagCfgCtrl
  import jtagCfgPkg::*;
#(
  parameter int W = 16,
  parameter int IR_W = 6,
  parameter logic [IR_W-1:0] IR_CFG_IN = 6'b000101,
  parameter logic [IR_W-1:0] IR_CFG_OUT = 6'b000100
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic stepEnd,
  input  logic riseNow,
  output ctl_t ctl,
  output logic tms,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(4 * W);
  localparam int LEN_W = CNT_W + 1;

  phase_t phase;
  logic [1:0] passIdx;
  logic [CNT_W-1:0] stepCnt;
  logic [LEN_W-1:0] stepLen;
  logic lastStep;
  logic [IR_W-1:0] irCode;
  logic [IR_W-1:0] irShifted;
  logic doneQ;

  always_comb begin
    case (phase)
      PH_TLR:     stepLen = LEN_W'(5);
      PH_IDLERUN: stepLen = LEN_W'(1);
      PH_IRBITS:  stepLen = LEN_W'(IR_W);
      PH_DRBITS:  stepLen = (passIdx == 2'd0) ? LEN_W'(4 * W) : LEN_W'(W);
      default:    stepLen = LEN_W'(2);
    endcase
  end

  assign lastStep  = ({1'b0, stepCnt} == (stepLen - LEN_W'(1)));
  assign irCode    = (passIdx == 2'd0) ? IR_CFG_IN : IR_CFG_OUT;
  assign irShifted = irCode >> stepCnt;

  always_comb begin
    case (phase)
      PH_IDLERUN, PH_INTOIR, PH_INTODR: tms = 1'b0;
      PH_IRBITS, PH_DRBITS:             tms = lastStep;
      default:                          tms = 1'b1;
    endcase
  end

  assign busy = (phase != PH_IDLE);
  assign done = doneQ;

  always_comb begin
    ctl            = '0;
    ctl.run        = busy;
    ctl.loadCmd    = (phase == PH_IDLE) && start;
    ctl.useIr      = (phase == PH_IRBITS);
    ctl.irBit      = irShifted[0];
    ctl.useCmd     = (phase == PH_DRBITS) && (passIdx == 2'd0);
    ctl.shiftCmd   = ctl.useCmd && stepEnd;
    ctl.captureBit = (phase == PH_DRBITS) && (passIdx == 2'd1) && riseNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      passIdx <= 2'd0;
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase   <= PH_TLR;
          passIdx <= 2'd0;
          stepCnt <= '0;
        end
      end else if (stepEnd) begin
        if (!lastStep) begin
          stepCnt <= stepCnt + CNT_W'(1);
        end else begin
          stepCnt <= '0;
          case (phase)
            PH_TLR: begin
              if (passIdx == 2'd2) begin
                phase <= PH_IDLE;
                doneQ <= 1'b1;
              end else begin
                phase <= PH_IDLERUN;
              end
            end
            PH_IDLERUN: phase <= PH_TOIR;
            PH_TOIR:    phase <= PH_INTOIR;
            PH_INTOIR:  phase <= PH_IRBITS;
            PH_IRBITS:  phase <= PH_TODR;
            PH_TODR:    phase <= PH_INTODR;
            PH_INTODR:  phase <= PH_DRBITS;
            default: begin
              phase   <= PH_TLR;
              passIdx <= passIdx + 2'd1;
            end
          endcase
        end
      end
    end
  end

  assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ({1'b0, stepCnt} < stepLen));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !stepEnd) |=> (phase == $past(phase)) && busy);

endmodule

// File: rtl/jtagCfgPath.sv
module jtagCfgPath
  import jtagCfgPkg::*;
#(
  parameter int W = 16,
  parameter int ADDR_W = 6,
  parameter int TAG_W = 5,
  parameter int DIV = 4,
  parameter logic [W-1:0] SYNC_WORD = 16'hAA99,
  parameter logic [W-1:0] NOOP_WORD = 16'h2000,
  parameter logic [TAG_W-1:0] HDR_TAG = 5'b00101
) (
  input  logic clk,
  input  logic rstN,
  input  ctl_t ctl,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic tdo,
  output logic tck,
  output logic tdi,
  output logic stepEnd,
  output logic riseNow,
  output logic [W-1:0] rdWord
);

  localparam int DIV_W  = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF   = DIV / 2;
  localparam int WCNT_W = W - TAG_W - ADDR_W;
  localparam int CMD_W  = 4 * W;

  logic [DIV_W-1:0] cntDiv;
  logic [CMD_W-1:0] cmdReg;
  logic [W-1:0] header;

  assign header  = {HDR_TAG, regAddr, WCNT_W'(1)};
  assign tck     = ctl.run && (cntDiv >= DIV_W'(HALF));
  assign stepEnd = ctl.run && (cntDiv == DIV_W'(DIV - 1));
  assign riseNow = ctl.run && (cntDiv == DIV_W'(HALF - 1));
  assign tdi     = ctl.useIr ? ctl.irBit : (ctl.useCmd ? cmdReg[CMD_W-1] : 1'b0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntDiv <= '0;
    end else if (!ctl.run || stepEnd) begin
      cntDiv <= '0;
    end else begin
      cntDiv <= cntDiv + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (ctl.loadCmd) begin
      cmdReg <= {SYNC_WORD, header, NOOP_WORD, NOOP_WORD};
    end else if (ctl.shiftCmd) begin
      cmdReg <= {cmdReg[CMD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdWord <= '0;
    end else if (ctl.captureBit) begin
      rdWord <= {rdWord[W-2:0], tdo};
    end
  end

  assert_idle_clock_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |-> !tck);

  assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> $stable(rdWord));

endmodule

// File: rtl/jtagCfgReader.sv
module jtagCfgReader
  import jtagCfgPkg::*;
#(
  parameter int W = 16,
  parameter int ADDR_W = 6,
  parameter int TAG_W = 5,
  parameter int DIV = 4,
  parameter int IR_W = 6,
  parameter logic [IR_W-1:0] IR_CFG_IN = 6'b000101,
  parameter logic [IR_W-1:0] IR_CFG_OUT = 6'b000100,
  parameter logic [W-1:0] SYNC_WORD = 16'hAA99,
  parameter logic [W-1:0] NOOP_WORD = 16'h2000,
  parameter logic [TAG_W-1:0] HDR_TAG = 5'b00101
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [ADDR_W-1:0] regAddr,
  output logic busy,
  output logic done,
  output logic [W-1:0] rdData,
  output logic tck,
  output logic tms,
  output logic tdi,
  input  logic tdo
);

  ctl_t ctl;
  logic stepEnd;
  logic riseNow;

  jtagCfgCtrl #(
    .W(W), .IR_W(IR_W), .IR_CFG_IN(IR_CFG_IN), .IR_CFG_OUT(IR_CFG_OUT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .stepEnd(stepEnd), .riseNow(riseNow),
    .ctl(ctl), .tms(tms), .busy(busy), .done(done)
  );

  jtagCfgPath #(
    .W(W), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .DIV(DIV),
    .SYNC_WORD(SYNC_WORD), .NOOP_WORD(NOOP_WORD), .HDR_TAG(HDR_TAG)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regAddr(regAddr), .tdo(tdo),
    .tck(tck), .tdi(tdi), .stepEnd(stepEnd), .riseNow(riseNow), .rdWord(rdData)
  );

  assert_lines_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    tck |-> ($stable(tms) && $stable(tdi)));

endmodule

// File: tb/sim_jtagCfgReader.sv
`timescale 1ns/1ps
module sim_jtagCfgReader;

  localparam int W = 16;
  localparam int DIV = 4;
  localparam int HALF = DIV / 2;
  localparam int TOTAL_TCK = 45 + 5 * W;
  localparam logic [5:0] IR_IN = 6'b000101;
  localparam logic [5:0] IR_OUT = 6'b000100;
  localparam logic [21:0] VEC [5] = '{
    {6'h00, 16'h1234}, {6'h3F, 16'hFFFF}, {6'h15, 16'h0001},
    {6'h2A, 16'h8000}, {6'h0C, 16'hA5C3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [5:0] regAddr = '0;
  logic busy, done, tck, tms, tdi;
  logic tdo = 1'b0;
  logic [W-1:0] rdData;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  jtagCfgReader u0 (
    .clk(clk), .rstN(rstN), .start(start), .regAddr(regAddr), .busy(busy),
    .done(done), .rdData(rdData), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  // behavioural target TAP
  typedef enum logic [3:0] {
    T_RESET, T_IDLE, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PSDR, T_EX2DR,
    T_UPDR, T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PSIR, T_EX2IR, T_UPIR
  } tap_t;

  tap_t tap = T_RESET;
  logic [5:0] irSh = '0;
  logic [5:0] ir = 6'b001001;
  logic [5:0] irHist [4];
  int irCount = 0;
  logic [4*W-1:0] cmdBits = '0;
  int cmdCnt = 0;
  logic [W-1:0] outSh = '0;
  logic [W-1:0] regVal = '0;
  logic tmsLog [256];
  int tckCnt = 0;

  function automatic tap_t tapNext(tap_t s, logic m);
    case (s)
      T_RESET: return m ? T_RESET : T_IDLE;
      T_IDLE:  return m ? T_SELDR : T_IDLE;
      T_SELDR: return m ? T_SELIR : T_CAPDR;
      T_CAPDR: return m ? T_EX1DR : T_SHDR;
      T_SHDR:  return m ? T_EX1DR : T_SHDR;
      T_EX1DR: return m ? T_UPDR : T_PSDR;
      T_PSDR:  return m ? T_EX2DR : T_PSDR;
      T_EX2DR: return m ? T_UPDR : T_SHDR;
      T_UPDR:  return m ? T_SELDR : T_IDLE;
      T_SELIR: return m ? T_RESET : T_CAPIR;
      T_CAPIR: return m ? T_EX1IR : T_SHIR;
      T_SHIR:  return m ? T_EX1IR : T_SHIR;
      T_EX1IR: return m ? T_UPIR : T_PSIR;
      T_PSIR:  return m ? T_EX2IR : T_PSIR;
      T_EX2IR: return m ? T_UPIR : T_SHIR;
      default: return m ? T_SELDR : T_IDLE;
    endcase
  endfunction

  always @(posedge tck) begin
    if (tckCnt < 256) tmsLog[tckCnt] = tms;
    tckCnt++;
    case (tap)
      T_RESET: ir = 6'b001001;
      T_CAPIR: irSh = 6'b000001;
      T_SHIR:  irSh = {tdi, irSh[5:1]};
      T_UPIR: begin
        ir = irSh;
        if (irCount < 4) irHist[irCount] = irSh;
        irCount++;
      end
      T_CAPDR: if (ir == IR_OUT) outSh = regVal;
      T_SHDR: begin
        if (ir == IR_IN) begin
          cmdBits = {cmdBits[4*W-2:0], tdi};
          cmdCnt++;
        end else if (ir == IR_OUT) begin
          outSh = {outSh[W-2:0], 1'b0};
        end
      end
      default: ;
    endcase
    tap = tapNext(tap, tms);
  end

  always @(negedge tck) tdo = (tap == T_SHDR && ir == IR_OUT) ? outSh[W-1] : 1'b0;

  // R2 line timing monitor
  int cyc = 0;
  int lastRise = -1;
  int lastFall = -1;
  int periodBad = 0;
  int edgeBad = 0;
  logic pTck = 1'b0, pTms = 1'b1, pTdi = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (tck && !pTck) begin
        if (lastRise >= 0 && (cyc - lastRise) != DIV) periodBad++;
        if (lastFall >= 0 && (cyc - lastFall) != HALF) periodBad++;
        lastRise = cyc;
      end
      if (!tck && pTck) begin
        if (lastRise >= 0 && (cyc - lastRise) != DIV - HALF) periodBad++;
        lastFall = cyc;
      end
      if (!busy && !tck) begin
        lastRise = -1;
        lastFall = -1;
      end
      if ((tms !== pTms || tdi !== pTdi) && !(pTck && !tck)) edgeBad++;
    end
    pTck = tck;
    pTms = tms;
    pTdi = tdi;
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic segTms(int j, int n);
    if (j < 5) return 1'b1;
    if (j == 5) return 1'b0;
    if (j < 8) return 1'b1;
    if (j < 10) return 1'b0;
    if (j < 16) return (j == 15);
    if (j < 18) return 1'b1;
    if (j < 20) return 1'b0;
    return (j == 20 + n - 1);
  endfunction

  function automatic logic expTms(int i);
    int nA = 20 + 4 * W;
    if (i < nA) return segTms(i, 4 * W);
    if (i < nA + 20 + W) return segTms(i - nA, W);
    return 1'b1;
  endfunction

  function automatic logic [4*W-1:0] expCmd(logic [5:0] a);
    return {16'hAA99, 5'b00101, a, 5'd1, 16'h2000, 16'h2000};
  endfunction

  task automatic clearLogs();
    tckCnt = 0;
    irCount = 0;
    cmdCnt = 0;
    cmdBits = '0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check("R8 done seen", {63'd0, done}, 64'd1);
    @(negedge clk);
    check("R8 done one cycle, busy low", {62'd0, done, busy}, 64'd0);
  endtask

  task automatic runAccess(logic [5:0] a, logic [W-1:0] v);
    int mism = 0;
    clearLogs();
    regVal = v;
    @(negedge clk);
    regAddr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after start", {63'd0, busy}, 64'd1);
    waitDone();
    check("R7 read word", {48'd0, rdData}, {48'd0, v});
    check("R6 command stream", cmdBits, expCmd(a));
    check("R6 command bit count", 64'(cmdCnt), 64'(4 * W));
    check("R4 instructions", {40'd0, irHist[0], irHist[1], 12'(irCount)},
          {40'd0, IR_IN, IR_OUT, 12'd2});
    for (int i = 0; i < TOTAL_TCK; i++) if (tmsLog[i] !== expTms(i)) mism++;
    check("R3 R5 tms walk", 64'(mism), 64'd0);
    check("R8 tck count", 64'(tckCnt), 64'(TOTAL_TCK));
    check("R3 target back in reset", {60'd0, tap}, {60'd0, T_RESET});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {59'd0, busy, done, tck, tms, tdi}, {59'd0, 5'b00010});
    check("R1 reset data", {48'd0, rdData}, 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle outputs", {59'd0, busy, done, tck, tms, tdi}, {59'd0, 5'b00010});

    foreach (VEC[k]) runAccess(VEC[k][21:16], VEC[k][15:0]);

    // R10: idle hold while the address moves
    regAddr = 6'h2B;
    repeat (40) @(negedge clk);
    check("R10 data held idle", {48'd0, rdData}, {48'd0, VEC[4][15:0]});
    check("R10 no clock idle", 64'(tckCnt), 64'(TOTAL_TCK));

    // R9: start during an access
    clearLogs();
    regVal = 16'h5A0F;
    @(negedge clk);
    regAddr = 6'h11;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    regAddr = 6'h22;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    check("R9 first address kept", cmdBits, expCmd(6'h11));
    check("R9 read after ignored start", {48'd0, rdData}, 64'h5A0F);
    repeat (700) @(negedge clk);
    check("R9 no second access", {31'd0, busy, 32'(tckCnt)}, {32'd0, 32'(TOTAL_TCK)});

    check("R2 tck period and phases", 64'(periodBad), 64'd0);
    check("R2 tms/tdi move on falling tck", 64'(edgeBad), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule